// File: doc/BRIEF.md
# Phase-Interpolation Synthesizer Pulse Controller

This block is the digital half of a frequency synthesizer that uses no lookup table. On every reference clock edge an N-bit accumulator advances by a programmable step. The register value goes out as a delay code for a phase interpolator placed downstream, and a strobe tells a downstream pulse generator to fire. The code selects a delay of code/2^N of one reference period.

When an addition carries out of the N-bit range, the block stalls for one reference cycle. In that cycle no pulse is requested and the register holds its value. Over time the pulse rate averages 2^N/(2^N+P) of the reference rate. A new step word is only committed when the register returns to its start state, so a pattern never changes partway through. Two instances can be chained by external wiring to form a cascaded synthesizer.

Top module: `pi_dds_core`

## Requirements
- R1: In every cycle with `pulse_en` high, the `phase_code` of the next cycle equals (`phase_code` + active step) modulo 2^N.
- R2: A load with `step_word` equal to 0 is ignored and the previously committed step stays in force. Every nonzero N-bit word (1 to 2^N−1) is accepted.
- R3: When a pulsed cycle's addition carries out of N bits, the next cycle has `pulse_en` low and `phase_code` unchanged. Pulsing resumes in the cycle after that.
- R4: `pulse_en` is high in every cycle that is neither a stall cycle nor the first cycle after reset, and in those cycles `phase_code` shows the current register value.
- R5: With a fixed step P, each stretch of 2^N+P cycles that starts at a period-start cycle contains exactly 2^N pulsed cycles.
- R6: `period_mark` is high for one cycle whenever the register is 0 and the cycle is pulsed. A word loaded earlier is pending until the next such cycle, and that cycle's addition already uses it. If several loads arrive before it, the last one wins.
- R7: Synchronous active-high `rst` clears the register to 0, drops any pending stall or pending word and sets the active step to 1. `pulse_en` is low during reset and in the first cycle after it.
- R8: `wrap_flag` is high exactly in the pulsed cycles whose addition carries out of N bits, and never in a cycle without a pulse.
- R9: The block works for N=4 with P=15 and for N=5 with P=1 (16 pulses per 31 cycles, 32 pulses per 33 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_word | input | ACC_W | Requested step value P |
| step_load | input | 1 | Loads `step_word` as the pending step when it is nonzero |
| phase_code | output | ACC_W | Delay code for the phase interpolator (register value) |
| pulse_en | output | 1 | Requests a pulse in this cycle |
| wrap_flag | output | 1 | This cycle's addition carries out of N bits |
| period_mark | output | 1 | Period-start cycle: register 0 and pulsed |

## Verification
The bench builds two instances side by side, one with N=4 and one with N=5. This covers both cascade stage settings, the largest step for the narrow width and the smallest step for the wide one. Running two widths at once shows that the carry detection and the stall length do not depend on a fixed width. A reference model in the bench predicts every cycle's strobe, code, wrap and mark through a scoreboard. Counting windows that start at a period mark check the pulse ratio for each step setting.

// File: rtl/pi_dds_pkg.sv
package pi_dds_pkg;

  // Cycle kind of the accumulator sequencer
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // first cycle after reset, no pulse
    PH_RUN   = 2'd1,  // pulsed cycle, register advances
    PH_STALL = 2'd2   // cycle after a carry, no pulse, no advance
  } phase_kind_t;

  localparam int unsigned RESET_STEP = 1;

endpackage

// File: rtl/pi_dds_step_hold.sv
module pi_dds_step_hold #(
  parameter int unsigned ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_req,
  input  logic [ACC_W-1:0] load_word,
  input  logic             commit,
  output logic [ACC_W-1:0] eff_step
);
  import pi_dds_pkg::*;

  logic [ACC_W-1:0] act_q;
  logic [ACC_W-1:0] pend_q;
  logic             pend_v;
  logic             load_ok;

  // Only words in 1..2^N-1 are legal; zero is the one illegal N-bit value
  function automatic logic word_legal(input logic [ACC_W-1:0] w);
    return (w != '0);
  endfunction

  assign load_ok  = load_req && word_legal(load_word);
  assign eff_step = (commit && pend_v) ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= ACC_W'(RESET_STEP);
      pend_q <= '0;
      pend_v <= 1'b0;
    end else begin
      act_q <= eff_step;
      if (load_ok) begin
        pend_q <= load_word;
        pend_v <= 1'b1;
      end else if (commit) begin
        pend_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pi_dds_accum.sv
module pi_dds_accum #(
  parameter int unsigned ACC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ACC_W-1:0]        step,
  output logic [ACC_W-1:0]        acc,
  output pi_dds_pkg::phase_kind_t kind,
  output logic                    carry
);
  import pi_dds_pkg::*;

  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  phase_kind_t      kind_q;
  logic [SUM_W-1:0] sum_w;

  function automatic logic [SUM_W-1:0] wide_add(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum_w = wide_add(acc_q, step);
  assign carry = (kind_q == PH_RUN) && sum_w[ACC_W];
  assign acc   = acc_q;
  assign kind  = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      kind_q <= PH_IDLE;
    end else begin
      unique case (kind_q)
        PH_RUN: begin
          acc_q  <= sum_w[ACC_W-1:0];
          kind_q <= sum_w[ACC_W] ? PH_STALL : PH_RUN;
        end
        default: kind_q <= PH_RUN;
      endcase
    end
  end

endmodule

// File: rtl/pi_dds_core.sv
module pi_dds_core #(
  parameter int unsigned ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_word,
  input  logic             step_load,
  output logic [ACC_W-1:0] phase_code,
  output logic             pulse_en,
  output logic             wrap_flag,
  output logic             period_mark
);
  import pi_dds_pkg::*;

  logic [ACC_W-1:0] act_step;
  logic [ACC_W-1:0] acc_val;
  phase_kind_t      cyc_kind;
  logic             add_carry;
  logic             at_start;

  assign at_start = (cyc_kind == PH_RUN) && (acc_val == '0);

  pi_dds_step_hold #(.ACC_W(ACC_W)) u_step (
    .clk       (clk),
    .rst       (rst),
    .load_req  (step_load),
    .load_word (step_word),
    .commit    (at_start),
    .eff_step  (act_step)
  );

  pi_dds_accum #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .step  (act_step),
    .acc   (acc_val),
    .kind  (cyc_kind),
    .carry (add_carry)
  );

  assign phase_code  = acc_val;
  assign pulse_en    = (cyc_kind == PH_RUN);
  assign wrap_flag   = add_carry;
  assign period_mark = at_start;

endmodule

// File: rtl/pi_dds_core_chk.sv
module pi_dds_core_chk #(
  parameter int unsigned ACC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] phase_code,
  input logic [ACC_W-1:0] act_step,
  input logic             pulse_en,
  input logic             wrap_flag,
  input logic             period_mark
);
  logic [ACC_W-1:0] next_code;
  assign next_code = phase_code + act_step;

  // R1
  accum_step_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_en |=> (phase_code == $past(next_code)));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pulse_en |=> (phase_code == $past(phase_code)));

  // R3
  wrap_gap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_flag |=> !pulse_en);

  // R8
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_flag |-> pulse_en);

  // R8
  no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_en && !wrap_flag) |=> (phase_code > $past(phase_code)));

  // R6
  mark_zero_chk: assert property (@(posedge clk) disable iff (rst)
    period_mark |-> (pulse_en && phase_code == '0));

  // R7
  reset_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pulse_en && phase_code == '0));

endmodule

bind pi_dds_core pi_dds_core_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .phase_code  (phase_code),
  .act_step    (act_step),
  .pulse_en    (pulse_en),
  .wrap_flag   (wrap_flag),
  .period_mark (period_mark)
);

// File: tb/pi_dds_core_test.sv
`timescale 1ns/1ps
module pi_dds_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] w4 = '0;
  logic       ld4 = 1'b0;
  logic [4:0] w5 = '0;
  logic       ld5 = 1'b0;
  logic [3:0] code4;
  logic [4:0] code5;
  logic       pe4, wr4, mk4, pe5, wr5, mk5;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pi_dds_core #(.ACC_W(4)) uut (
    .clk(clk), .rst(rst), .step_word(w4), .step_load(ld4),
    .phase_code(code4), .pulse_en(pe4), .wrap_flag(wr4), .period_mark(mk4));

  pi_dds_core #(.ACC_W(5)) uut_w5 (
    .clk(clk), .rst(rst), .step_word(w5), .step_load(ld5),
    .phase_code(code5), .pulse_en(pe5), .wrap_flag(wr5), .period_mark(mk5));

  typedef struct {
    int idx;
    bit pulse;
    int code;
    bit wrap;
    bit mark;
  } exp_t;

  exp_t sb_q[$];

  // reference model state: kind 0 idle, 1 run, 2 stall
  int m_acc[2], m_kind[2], m_step[2], m_pend[2];
  bit m_pv[2];
  int m_mod[2] = '{16, 32};

  task automatic model_reset(int i);
    m_acc[i] = 0; m_kind[i] = 0; m_step[i] = 1; m_pend[i] = 0; m_pv[i] = 0;
  endtask

  task automatic check(bit ok, string req, int act, int exp_v, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // driver: applies inputs, pushes expected outputs, advances the model
  task automatic cycle(bit r, bit l4, int v4, bit l5, int v5);
    @(negedge clk);
    rst = r; ld4 = l4; w4 = 4'(v4); ld5 = l5; w5 = 5'(v5);
    for (int i = 0; i < 2; i++) begin
      exp_t e;
      bit ld; int v; int eff;
      ld = (i == 0) ? l4 : l5;
      v  = (i == 0) ? v4 : v5;
      e.idx   = i;
      e.pulse = (m_kind[i] == 1);
      e.code  = m_acc[i];
      e.mark  = e.pulse && (m_acc[i] == 0);
      eff     = (e.mark && m_pv[i]) ? m_pend[i] : m_step[i];
      e.wrap  = e.pulse && (m_acc[i] + eff >= m_mod[i]);
      sb_q.push_back(e);
      if (r) model_reset(i);
      else begin
        if (e.mark) m_step[i] = eff;
        if (ld && v != 0) begin m_pend[i] = v; m_pv[i] = 1; end
        else if (e.mark) m_pv[i] = 0;
        if (m_kind[i] == 1) begin
          m_acc[i]  = (m_acc[i] + eff) % m_mod[i];
          m_kind[i] = e.wrap ? 2 : 1;
        end else m_kind[i] = 1;
      end
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 0, 0, 0);
  endtask

  // monitor: pops expectations and compares with the ports
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      bit pe, wr, mk; int cd;
      e  = sb_q.pop_front();
      pe = (e.idx == 0) ? pe4 : pe5;
      wr = (e.idx == 0) ? wr4 : wr5;
      mk = (e.idx == 0) ? mk4 : mk5;
      cd = (e.idx == 0) ? int'(code4) : int'(code5);
      check(pe == e.pulse, "R4/R3", pe, e.pulse, "pulse_en");
      check(cd == e.code,  "R1",    cd, e.code,  "phase_code");
      check(wr == e.wrap,  "R8",    wr, e.wrap,  "wrap_flag");
      check(mk == e.mark,  "R6",    mk, e.mark,  "period_mark");
    end
  end

  // counts pulses of one instance over len cycles from its next period start
  task automatic ratio(int i, int len, int want, string req);
    int cnt = 0;
    while (!(m_kind[i] == 1 && m_acc[i] == 0)) idle(1);
    for (int k = 0; k < len; k++) begin
      idle(1);
      #1;
      cnt += (i == 0) ? int'(pe4) : int'(pe5);
    end
    check(cnt == want, req, cnt, want, "pulse count");
  endtask

  initial begin
    model_reset(0);
    model_reset(1);
    // R7: reset state
    repeat (3) cycle(1, 0, 0, 0, 0);
    #1;
    check(pe4 == 0 && code4 == 0, "R7", pe4, 0, "reset pulse_en uut");
    check(pe5 == 0 && code5 == 0, "R7", pe5, 0, "reset pulse_en uut_w5");
    cycle(0, 0, 0, 0, 0);
    #1;
    check(pe4 == 0, "R7", pe4, 0, "first cycle after reset");
    // default step 1: 16 pulses per 17 cycles (R5)
    ratio(0, 17, 16, "R5");
    // R9: N=4 with P=15 and N=5 with P=1
    cycle(0, 1, 15, 1, 1);
    ratio(0, 31 * 3, 16 * 3, "R9");
    ratio(1, 33 * 3, 32 * 3, "R9");
    // R2: zero word ignored, old steps stay
    cycle(0, 1, 0, 1, 0);
    idle(40);
    ratio(0, 31, 16, "R2");
    ratio(1, 33, 32, "R2");
    // R6: mid-period loads, last one wins at next start
    idle(5);
    cycle(0, 1, 5, 1, 31);
    cycle(0, 1, 3, 1, 7);
    ratio(0, 19 * 2, 16 * 2, "R6");
    ratio(1, 39 * 2, 32 * 2, "R6");
    // R5: upper bound step for N=5
    cycle(0, 0, 0, 1, 31);
    ratio(1, 63, 32, "R5");
    // R7: reset in mid-run
    idle(7);
    cycle(1, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    #1;
    check(pe5 == 0 && code5 == 0, "R7", pe5, 0, "mid-run reset gap");
    ratio(1, 33, 32, "R7");
    idle(3);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule